// File: doc/BRIEF.md
# Periodic Interval Timer with Shadowed Compare Channels

This block is a 16-bit up-counter that produces a periodic interrupt. A period register sets the length of each interval, and a second compare register gives a mid-interval interrupt. The counter advances by one on each cycle where the count-clock enable input is high. When it reaches the active period value, it returns to zero on that same tick and raises a one-cycle period interrupt.

Software never compares against the registers it writes. Each compare register is copied into a shadow buffer when the timer starts and again at every period match. The counter is compared only against these shadows, so a write made in the middle of an interval has no effect until that interval ends.

The block has two output pins. Each pin can show a toggling waveform or a fixed level. The live count is always visible on an output port.

Top module: `ivt_top`

## Requirements
- R1: The counter is 16 bits and is always visible on `cntValue`. While the timer runs, it increases by one at each clock edge where `cntTick` is high and the counter has not reached the period shadow.
- R2: With period shadow value D, the tick at which the counter equals D returns it to 0x0000. `perIrq` is high in the single following cycle. With `cntTick` held high, successive period interrupts are D+1 cycles apart, including for D = 0 and D = 0xFFFF.
- R3: When the counter equals the compare shadow on a tick, `cmpIrq` is high in the single following cycle. This happens in interval mode whether or not a period match occurs on the same tick.
- R4: Both shadows are loaded from their registers on the start cycle and at each period match. A register write at any other time changes no comparison until the next period match.
- R5: A disabled output pin (enable bit 0) drives its level bit: 0 gives low and 1 gives high.
- R6: While `out0En` is 1, `pin0` starts at `out0Lvl` when the timer starts and inverts at every period match.
- R7: While `out1En` is 1, `pin1` starts at `out1Lvl` when the timer starts and inverts at every compare-channel match.
- R8: The timer runs only while `run` is 1 and `modeSel` is 3'b000. Any other mode value, or `run` at 0, holds the counter at 0x0000 and raises no interrupts.
- R9: The first cycle with the timer enabled is a start cycle. It does not count, and the counter holds 0x0000 during it. Counting begins with the next tick.
- R10: After reset, the counter is 0x0000, both interrupts are low, and both register values and toggle states are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Count-clock enable |
| run | input | 1 | Run enable |
| modeSel | input | 3 | Operating mode, 000 = interval |
| perWr | input | 1 | Write strobe for period register |
| perData | input | 16 | Period register write data |
| cmpWr | input | 1 | Write strobe for compare register |
| cmpData | input | 16 | Compare register write data |
| out0En | input | 1 | Pin 0 toggle enable |
| out0Lvl | input | 1 | Pin 0 static/initial level |
| out1En | input | 1 | Pin 1 toggle enable |
| out1Lvl | input | 1 | Pin 1 static/initial level |
| cntValue | output | 16 | Live counter value |
| perIrq | output | 1 | Period match interrupt pulse |
| cmpIrq | output | 1 | Compare match interrupt pulse |
| pin0 | output | 1 | Output pin 0 |
| pin1 | output | 1 | Output pin 1 |

## Verification
A corrupted counter or shadow shows up on `cntValue` at the next sampled cycle. It also moves the following interrupt away from its expected cycle, which can be as much as one full interval later. A toggle flip-flop that is wrong is seen on its pin as soon as that pin is enabled. A shadow that reloads at the wrong moment is exposed by a write made mid-interval: the period that follows has the wrong length. The reference model follows every port on every cycle, so any such divergence is reported in the cycle where it first reaches a port.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W  = 16;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_INTERVAL = '0;

  typedef struct packed {
    logic clr;   // hold counter at zero
    logic load;  // start cycle: fill shadows, preset toggles
    logic inc;   // counting tick
    logic wrap;  // period match on this tick
    logic tog1;  // compare match on this tick
  } strobe_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntTick,
  input  logic          run,
  input  logic [MW-1:0] modeSel,
  input  logic          perHit,
  input  logic          cmpHit,
  output strobe_t       strb,
  output logic          perIrq,
  output logic          cmpIrq
);
  logic active;
  logic activeQ;
  logic startCyc;

  assign active   = run && (modeSel == MW'(MODE_INTERVAL));
  assign startCyc = active && !activeQ;

  always_comb begin
    strb      = '0;
    strb.clr  = !active;
    strb.load = startCyc;
    strb.inc  = active && !startCyc && cntTick;
    strb.wrap = strb.inc && perHit;
    strb.tog1 = strb.inc && cmpHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      perIrq  <= 1'b0;
      cmpIrq  <= 1'b0;
    end else begin
      activeQ <= active;
      perIrq  <= strb.wrap;
      cmpIrq  <= strb.tog1;
    end
  end

  // R8
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != '0 || !run) |=> (!perIrq && !cmpIrq));

  // R9
  start_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !perIrq && !cmpIrq);
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic         perWr,
  input  logic [W-1:0] perData,
  input  logic         cmpWr,
  input  logic [W-1:0] cmpData,
  input  logic         out0En,
  input  logic         out0Lvl,
  input  logic         out1En,
  input  logic         out1Lvl,
  output logic [W-1:0] cntValue,
  output logic         perHit,
  output logic         cmpHit,
  output logic         pin0,
  output logic         pin1
);
  logic [W-1:0] cnt;
  logic [W-1:0] perReg;
  logic [W-1:0] cmpReg;
  logic [W-1:0] perBuf;
  logic [W-1:0] cmpBuf;
  logic         tog0;
  logic         tog1;

  assign perHit   = (cnt == perBuf);
  assign cmpHit   = (cnt == cmpBuf);
  assign cntValue = cnt;
  assign pin0     = out0En ? tog0 : out0Lvl;
  assign pin1     = out1En ? tog1 : out1Lvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg <= '0;
      cmpReg <= '0;
    end else begin
      if (perWr) perReg <= perData;
      if (cmpWr) cmpReg <= cmpData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clr || strb.load || strb.wrap) begin
      cnt <= '0;
    end else if (strb.inc) begin
      cnt <= cnt + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perBuf <= '0;
      cmpBuf <= '0;
    end else if (strb.load || strb.wrap) begin
      perBuf <= perReg;
      cmpBuf <= cmpReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tog0 <= 1'b0;
      tog1 <= 1'b0;
    end else if (strb.load) begin
      tog0 <= out0Lvl;
      tog1 <= out1Lvl;
    end else begin
      if (strb.wrap) tog0 <= !tog0;
      if (strb.tog1) tog1 <= !tog1;
    end
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> cnt == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.wrap && !strb.clr) |=> cnt == $past(cnt) + W'(1));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (cnt == '0) && (perBuf == $past(perReg)));

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.wrap) |=> $stable(perBuf) && $stable(cmpBuf));
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntTick,
  input  logic          run,
  input  logic [MW-1:0] modeSel,
  input  logic          perWr,
  input  logic [W-1:0]  perData,
  input  logic          cmpWr,
  input  logic [W-1:0]  cmpData,
  input  logic          out0En,
  input  logic          out0Lvl,
  input  logic          out1En,
  input  logic          out1Lvl,
  output logic [W-1:0]  cntValue,
  output logic          perIrq,
  output logic          cmpIrq,
  output logic          pin0,
  output logic          pin1
);
  strobe_t strb;
  logic    perHit;
  logic    cmpHit;

  ivt_ctrl #(.MW(MW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .run(run), .modeSel(modeSel),
    .perHit(perHit), .cmpHit(cmpHit), .strb(strb),
    .perIrq(perIrq), .cmpIrq(cmpIrq)
  );

  ivt_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .perWr(perWr), .perData(perData), .cmpWr(cmpWr), .cmpData(cmpData),
    .out0En(out0En), .out0Lvl(out0Lvl), .out1En(out1En), .out1Lvl(out1Lvl),
    .cntValue(cntValue), .perHit(perHit), .cmpHit(cmpHit),
    .pin0(pin0), .pin1(pin1)
  );
endmodule

// File: tb/ivt_top_tb.sv
`timescale 1ns/1ps
module ivt_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0, run = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic perWr = 1'b0, cmpWr = 1'b0;
  logic [15:0] perData = '0, cmpData = '0;
  logic out0En = 1'b0, out0Lvl = 1'b0, out1En = 1'b0, out1Lvl = 1'b0;
  logic [15:0] cntValue;
  logic perIrq, cmpIrq, pin0, pin1;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ivt_top u_dut (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .run(run), .modeSel(modeSel),
    .perWr(perWr), .perData(perData), .cmpWr(cmpWr), .cmpData(cmpData),
    .out0En(out0En), .out0Lvl(out0Lvl), .out1En(out1En), .out1Lvl(out1Lvl),
    .cntValue(cntValue), .perIrq(perIrq), .cmpIrq(cmpIrq), .pin0(pin0), .pin1(pin1)
  );

  // behavioural reference state
  int  mCnt, mPerReg, mCmpReg, mPerBuf, mCmpBuf;
  bit  mTog0, mTog1, mWas, mPerIrq, mCmpIrq;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit act, start, pN, cN;
    pN = 0; cN = 0;
    if (!rstN) begin
      mCnt = 0; mPerReg = 0; mCmpReg = 0; mPerBuf = 0; mCmpBuf = 0;
      mTog0 = 0; mTog1 = 0; mWas = 0;
    end else begin
      act = run && (modeSel == 3'd0);
      start = act && !mWas;
      if (!act) mCnt = 0;
      else if (start) begin
        mCnt = 0; mPerBuf = mPerReg; mCmpBuf = mCmpReg;
        mTog0 = out0Lvl; mTog1 = out1Lvl;
      end else if (cntTick) begin
        if (mCnt == mCmpBuf) begin cN = 1; mTog1 = !mTog1; end
        if (mCnt == mPerBuf) begin
          pN = 1; mCnt = 0; mPerBuf = mPerReg; mCmpBuf = mCmpReg; mTog0 = !mTog0;
        end else mCnt = mCnt + 1;
      end
      mWas = act;
      if (perWr) mPerReg = perData;
      if (cmpWr) mCmpReg = cmpData;
    end
    mPerIrq = pN; mCmpIrq = cN;
  endtask

  // one clock: model advances at the edge, ports compared mid-cycle
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      chk(cntValue == 16'(mCnt), "R1 counter", cntValue, mCnt);
      chk(perIrq == mPerIrq, "R2 period irq", perIrq, mPerIrq);
      chk(cmpIrq == mCmpIrq, "R3 compare irq", cmpIrq, mCmpIrq);
      chk(pin0 == (out0En ? mTog0 : out0Lvl), "R6 pin0", pin0, out0En ? mTog0 : out0Lvl);
      chk(pin1 == (out1En ? mTog1 : out1Lvl), "R7 pin1", pin1, out1En ? mTog1 : out1Lvl);
    end
  endtask

  task automatic wrPer(input logic [15:0] v);
    perData = v; perWr = 1'b1; cyc(1); perWr = 1'b0;
  endtask

  task automatic wrCmp(input logic [15:0] v);
    cmpData = v; cmpWr = 1'b1; cyc(1); cmpWr = 1'b0;
  endtask

  // cycles stepped until perIrq is seen high
  task automatic waitPer(output int n);
    n = 0;
    do begin cyc(1); n++; end while (!perIrq && n < 70000);
  endtask

  task automatic waitCmp(output int n);
    n = 0;
    do begin cyc(1); n++; end while (!cmpIrq && n < 70000);
  endtask

  task automatic stopTimer();
    run = 1'b0; cyc(2);
  endtask

  initial begin
    #(1_900_000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int g;
    @(negedge clk);
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R10 reset state
    chk(cntValue == 16'h0, "R10 reset count", cntValue, 0);
    chk(!perIrq && !cmpIrq, "R10 reset irqs", {perIrq, cmpIrq}, 0);

    // R5 static pin levels while disabled
    out0Lvl = 1'b1; out1Lvl = 1'b0; cyc(1);
    chk(pin0 == 1'b1, "R5 pin0 high", pin0, 1);
    chk(pin1 == 1'b0, "R5 pin1 low", pin1, 0);
    out0Lvl = 1'b0; out1Lvl = 1'b1; cyc(1);
    chk(pin0 == 1'b0, "R5 pin0 low", pin0, 0);
    chk(pin1 == 1'b1, "R5 pin1 high", pin1, 1);

    // R8 non-interval mode keeps counter stopped
    wrPer(16'd3); wrCmp(16'd1);
    modeSel = 3'd5; run = 1'b1; cntTick = 1'b1;
    cyc(10);
    chk(cntValue == 0, "R8 other mode count", cntValue, 0);
    chk(!perIrq && !cmpIrq, "R8 other mode irqs", {perIrq, cmpIrq}, 0);
    run = 1'b0; modeSel = 3'd0; cyc(1);

    // R9 start cycle does not count
    run = 1'b1; cyc(1);
    chk(cntValue == 0, "R9 start cycle", cntValue, 0);
    cyc(1);
    chk(cntValue == 1, "R9 first tick", cntValue, 1);
    stopTimer();

    // R2 interval D=0 and D=1
    wrPer(16'd0); run = 1'b1;
    waitPer(g); waitPer(g);
    chk(g == 1, "R2 interval D=0", g, 1);
    stopTimer();
    wrPer(16'd1); run = 1'b1;
    waitPer(g); waitPer(g);
    chk(g == 2, "R2 interval D=1", g, 2);
    stopTimer();

    // R3 compare channel timing, R6/R7 toggling, gated ticks
    out0En = 1'b1; out1En = 1'b1; out0Lvl = 1'b1; out1Lvl = 1'b0;
    wrPer(16'd9); wrCmp(16'd3); run = 1'b1;
    waitPer(g);
    waitCmp(g);
    chk(g == 4, "R3 compare delay", g, 4);
    waitPer(g);
    chk(g == 6, "R2 period after compare", g, 6);
    for (int i = 0; i < 40; i++) begin cntTick = i[0]; cyc(1); end
    cntTick = 1'b1;

    // R4 mid-interval writes wait for period match
    waitPer(g);
    cyc(2); wrPer(16'd4);
    waitPer(g);
    chk(g == 7, "R4 old period kept", g, 7);
    waitPer(g);
    chk(g == 5, "R4 new period used", g, 5);
    wrCmp(16'd2);
    waitPer(g); waitCmp(g);
    chk(g == 3, "R4 new compare used", g, 3);
    stopTimer();
    out0En = 1'b0; out1En = 1'b0;

    // R2 interval D=0xFFFF
    wrPer(16'hFFFF); wrCmp(16'hFFFF); run = 1'b1;
    waitPer(g); waitPer(g);
    chk(g == 65536, "R2 interval D=FFFF", g, 65536);
    stopTimer();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule